// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Controller

This block decides which of five hardware interrupt requests a processor core takes. It decides only when the core reports that it has reached an instruction boundary. One source is non-maskable and outranks all the others. Three maskable sources each send the core to a fixed 16-bit entry address. The lowest-ranked source returns no address of its own. When it wins, the controller pulses an acknowledge so that external logic can put an instruction on the bus. The controller holds a mask bit for each fixed-address maskable source and a global enable flag. It also reports which requests are pending.

The core raises `boundary_i` for one cycle at each instruction boundary. On the next cycle the controller answers with a one-cycle `take_o` pulse that carries `vector_o`. When the lowest-ranked source wins, the answer also carries `ext_ack_o`. The core loads the enable and mask state through simple strobes. It reads that state back on `ie_o`, `mask_o` and `pending_o`. Stacking the return address and fetching the vector are the core's job and are not part of this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_i` is high, and on the cycle after it is sampled high, `take_o`=0, `ext_ack_o`=0, `ie_o`=0, `mask_o`=3'b111 and the two latched pending bits (`pending_o[4]` and `pending_o[3]`) are 0.
- R2: Requests are decided only on a clock edge where `boundary_i`=1. `take_o` is high for exactly the one cycle after that edge, and only when some source qualifies.
- R3: When several sources qualify at once, the winner is chosen in this order: NMI, then high, then middle, then low, then external.
- R4: The vectors are NMI 0x0024, high 0x003C, middle 0x0034 and low 0x002C. When the external source wins, `vector_o`=0x0000 and `ext_ack_o` is high together with `take_o`. `ext_ack_o` is never high at any other time.
- R5: The NMI source qualifies when its latch holds a rising edge and `nmi_i` is still high at the deciding edge. Neither `ie_o` nor the mask affects it. Taking the NMI clears its latch.
- R6: The high, middle, low and external sources qualify only when `ie_o`=1. The first three also need their mask bit to be 0. The mask bits are: bit 2 high, bit 1 middle, bit 0 low.
- R7: A rising edge on `irq_hi_i` sets a latch even while that source is masked or disabled. The latch stays set after the input falls. It is cleared when the high source is taken, or by a mask write with `mask_wdata_i[3]`=1. A new edge in the same cycle as a clear still sets the latch.
- R8: The middle, low and external sources are level inputs with no memory. They qualify only if they are high at the deciding edge.
- R9: Taking any source clears `ie_o` on the same edge that sets `take_o`. If nothing is taken, `ie_clr_i` clears `ie_o`, and otherwise `ie_set_i` sets it. `ie_clr_i` wins over `ie_set_i`.
- R10: A mask write (`mask_wr_i`=1) loads `mask_o` from `mask_wdata_i[2:0]` on the next edge. `pending_o` shows, from bit 4 down to bit 0, the NMI latch, the high latch, `irq_mid_i`, `irq_lo_i` and `ext_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe; requests are decided on this edge |
| ie_set_i | input | 1 | Set the global enable |
| ie_clr_i | input | 1 | Clear the global enable |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | [2:0] new mask bits, [3] clears the high latch |
| nmi_i | input | 1 | Non-maskable request; needs a rising edge and must still be high |
| irq_hi_i | input | 1 | High maskable request; rising-edge latched |
| irq_mid_i | input | 1 | Middle maskable request; level |
| irq_lo_i | input | 1 | Low maskable request; level |
| ext_req_i | input | 1 | External-vector request; level, lowest rank |
| take_o | output | 1 | One-cycle pulse: an interrupt was accepted |
| vector_o | output | 16 | Entry address of the accepted source |
| ext_ack_o | output | 1 | Acknowledge pulse for the external source |
| ie_o | output | 1 | Global enable state |
| mask_o | output | 3 | Mask state |
| pending_o | output | 5 | Pending view of all five sources |

## Verification
The bench tries the decision logic with overlapping requests of mixed rank, so that only the priority order can explain which source wins. It lowers each level input before the strobe, to separate the level sources from the latched high source. It drives the NMI as a short pulse and as a held level, so that the edge-plus-level rule can be seen. A long random phase with rare strobes, enable toggles and latch-clear mask writes is compared against a behavioural model on every cycle. That phase finds races between taking an interrupt and the enable controls, and between a new edge and a latch clear.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int VEC_W   = 16;
    localparam int MASK_W  = 3;

    // bit positions inside the request / pending vectors (priority rises with index)
    localparam int IDX_EXT = 0;
    localparam int IDX_LO  = 1;
    localparam int IDX_MID = 2;
    localparam int IDX_HI  = 3;
    localparam int IDX_NMI = 4;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_HI,
        SRC_MID,
        SRC_LO,
        SRC_EXT
    } src_e;

    typedef struct packed {
        logic             take;
        logic             ext_ack;
        logic [VEC_W-1:0] vector;
    } accept_t;

    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_NMI: return VEC_W'(16'h0024);
            SRC_HI:  return VEC_W'(16'h003C);
            SRC_MID: return VEC_W'(16'h0034);
            SRC_LO:  return VEC_W'(16'h002C);
            default: return '0;
        endcase
    endfunction

    function automatic src_e src_of(logic [NUM_SRC-1:0] onehot);
        src_e s;
        s = SRC_NONE;
        if (onehot[IDX_NMI])      s = SRC_NMI;
        else if (onehot[IDX_HI])  s = SRC_HI;
        else if (onehot[IDX_MID]) s = SRC_MID;
        else if (onehot[IDX_LO])  s = SRC_LO;
        else if (onehot[IDX_EXT]) s = SRC_EXT;
        return s;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic rise;

    assign rise = lvl_i & ~prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            pend_o <= (pend_o & ~clr_i) | rise;
        end
    end

    // R7: a latched request survives until a clear arrives
    p_latch_holds_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_o && !clr_i) |=> pend_o);

    // R7: an edge always leaves the latch set
    p_edge_sets_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_i && !prev_q) |=> pend_o);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    logic [N:0] higher;

    assign higher[N] = 1'b0;

    for (genvar i = N - 1; i >= 0; i--) begin : g_rank
        assign grant_o[i] = req_i[i] & ~higher[i+1];
        assign higher[i]  = higher[i+1] | req_i[i];
    end
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl #(
    parameter int MW = 3
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          accept_i,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic          mask_wr_i,
    input  logic [MW-1:0] mask_d_i,
    output logic          ie_o,
    output logic [MW-1:0] mask_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ie_o   <= 1'b0;
            mask_o <= '1;
        end else begin
            if (accept_i)   ie_o <= 1'b0;
            else if (clr_i) ie_o <= 1'b0;
            else if (set_i) ie_o <= 1'b1;
            if (mask_wr_i) mask_o <= mask_d_i;
        end
    end

    // R9: accepting wins over a simultaneous enable
    p_accept_disables_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        accept_i |=> !ie_o);

    // R10: mask holds between writes
    p_mask_stable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !mask_wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             boundary_i,
    input  logic             ie_set_i,
    input  logic             ie_clr_i,
    input  logic             mask_wr_i,
    input  logic [3:0]       mask_wdata_i,
    input  logic             nmi_i,
    input  logic             irq_hi_i,
    input  logic             irq_mid_i,
    input  logic             irq_lo_i,
    input  logic             ext_req_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             ext_ack_o,
    output logic             ie_o,
    output logic [2:0]       mask_o,
    output logic [4:0]       pending_o
);
    localparam int HI_CLR_BIT = MASK_W;

    logic               nmi_pend, hi_pend;
    logic               nmi_clr, hi_clr;
    logic [NUM_SRC-1:0] qualify, grant;
    logic               accept;
    src_e               winner;
    accept_t            acc_d, acc_q;

    irq_edge_latch u_nmi_latch (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (nmi_i),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    irq_edge_latch u_hi_latch (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (irq_hi_i),
        .clr_i  (hi_clr),
        .pend_o (hi_pend)
    );

    always_comb begin
        qualify          = '0;
        qualify[IDX_NMI] = nmi_pend & nmi_i;
        qualify[IDX_HI]  = ie_o & ~mask_o[2] & hi_pend;
        qualify[IDX_MID] = ie_o & ~mask_o[1] & irq_mid_i;
        qualify[IDX_LO]  = ie_o & ~mask_o[0] & irq_lo_i;
        qualify[IDX_EXT] = ie_o & ext_req_i;
    end

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .req_i   (qualify),
        .grant_o (grant)
    );

    assign accept  = boundary_i & (|qualify);
    assign winner  = accept ? src_of(grant) : SRC_NONE;
    assign nmi_clr = (winner == SRC_NMI);
    assign hi_clr  = (winner == SRC_HI) | (mask_wr_i & mask_wdata_i[HI_CLR_BIT]);

    always_comb begin
        acc_d.take    = accept;
        acc_d.ext_ack = (winner == SRC_EXT);
        acc_d.vector  = accept ? vec_of(winner) : acc_q.vector;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) acc_q <= '0;
        else       acc_q <= acc_d;
    end

    irq_enable_ctl #(.MW(MASK_W)) u_enable (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .accept_i  (accept),
        .set_i     (ie_set_i),
        .clr_i     (ie_clr_i),
        .mask_wr_i (mask_wr_i),
        .mask_d_i  (mask_wdata_i[MASK_W-1:0]),
        .ie_o      (ie_o),
        .mask_o    (mask_o)
    );

    assign take_o    = acc_q.take;
    assign vector_o  = acc_q.vector;
    assign ext_ack_o = acc_q.ext_ack;
    assign pending_o = {nmi_pend, hi_pend, irq_mid_i, irq_lo_i, ext_req_i};

    // R2: an acceptance only follows a boundary strobe
    p_take_after_strobe_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> $past(boundary_i));

    // R9: every acceptance leaves the enable cleared
    p_take_clears_ie_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> !ie_o);

    // R4: the acknowledge comes only with an external acceptance
    p_ack_with_take_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ext_ack_o |-> (take_o && vector_o == '0));

    // R5: an NMI acceptance needs the NMI level at the deciding edge
    p_nmi_level_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_o && vector_o == 16'h0024) |-> $past(nmi_i));

    // R6: a maskable acceptance needs the enable to have been set
    p_masked_need_ie_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (take_o && vector_o != 16'h0024) |-> $past(ie_o));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary = 0, ie_set = 0, ie_clr = 0, mask_wr = 0;
    logic [3:0]  mask_wdata = '0;
    logic        nmi = 0, hi = 0, mid = 0, lo = 0, ext = 0;
    logic        take, ext_ack, ie;
    logic [15:0] vector;
    logic [2:0]  mask;
    logic [4:0]  pending;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk_i(clk), .rst_i(rst), .boundary_i(boundary),
        .ie_set_i(ie_set), .ie_clr_i(ie_clr), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .nmi_i(nmi), .irq_hi_i(hi),
        .irq_mid_i(mid), .irq_lo_i(lo), .ext_req_i(ext),
        .take_o(take), .vector_o(vector), .ext_ack_o(ext_ack),
        .ie_o(ie), .mask_o(mask), .pending_o(pending)
    );

    // behavioural reference model
    bit          m_ie, m_take, m_ack, m_nmi_lat, m_hi_lat, m_nmi_prev, m_hi_prev;
    bit [2:0]    m_mask;
    bit [15:0]   m_vec;

    always @(posedge clk) begin
        int        pick;
        bit [15:0] table_vec [5];
        bit        cand [5];
        bit        nmi_edge, hi_edge, clr_hi, clr_nmi;
        table_vec = '{16'h0024, 16'h003C, 16'h0034, 16'h002C, 16'h0000};
        if (rst) begin
            m_ie = 0; m_take = 0; m_ack = 0; m_nmi_lat = 0; m_hi_lat = 0;
            m_nmi_prev = 0; m_hi_prev = 0; m_mask = 3'b111; m_vec = 0;
        end else begin
            cand[0] = m_nmi_lat && nmi;
            cand[1] = m_ie && !m_mask[2] && m_hi_lat;
            cand[2] = m_ie && !m_mask[1] && mid;
            cand[3] = m_ie && !m_mask[0] && lo;
            cand[4] = m_ie && ext;
            pick = -1;
            if (boundary)
                foreach (cand[k]) if (pick < 0 && cand[k]) pick = k;
            nmi_edge = nmi && !m_nmi_prev;
            hi_edge  = hi && !m_hi_prev;
            clr_nmi  = (pick == 0);
            clr_hi   = (pick == 1) || (mask_wr && mask_wdata[3]);
            m_nmi_lat = (m_nmi_lat && !clr_nmi) || nmi_edge;
            m_hi_lat  = (m_hi_lat && !clr_hi) || hi_edge;
            m_nmi_prev = nmi;
            m_hi_prev  = hi;
            m_take = (pick >= 0);
            m_ack  = (pick == 4);
            if (pick >= 0) m_vec = table_vec[pick];
            if (pick >= 0)   m_ie = 0;
            else if (ie_clr) m_ie = 0;
            else if (ie_set) m_ie = 1;
            if (mask_wr) m_mask = mask_wdata[2:0];
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 take", 32'(take), 32'(m_take));
            if (m_take) chk("R4 vector", 32'(vector), 32'(m_vec));
            chk("R4 ext_ack", 32'(ext_ack), 32'(m_ack));
            chk("R9 ie", 32'(ie), 32'(m_ie));
            chk("R10 mask", 32'(mask), 32'(m_mask));
            chk("R7 pending", 32'(pending), 32'({m_nmi_lat, m_hi_lat, mid, lo, ext}));
        end
    end

    task automatic idle();
        @(negedge clk);
        boundary = 0; ie_set = 0; ie_clr = 0; mask_wr = 0; mask_wdata = '0;
    endtask

    task automatic strobe();
        boundary = 1;
        @(negedge clk);
        boundary = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 take", 32'(take), 0);
        chk("R1 ie", 32'(ie), 0);
        chk("R1 mask", 32'(mask), 32'h7);
        chk("R1 latches", 32'(pending[4:3]), 0);
        rst = 0;
        idle();

        // R10 / R9: unmask all and enable
        mask_wr = 1; mask_wdata = 4'b0000; ie_set = 1;
        idle();
        chk("R10 mask load", 32'(mask), 0);
        chk("R9 enable set", 32'(ie), 1);

        // R3: middle beats low
        mid = 1; lo = 1;
        strobe();
        chk("R3 mid wins", 32'(vector), 32'h0034);
        chk("R9 ie cleared", 32'(ie), 0);

        // R6: disabled, nothing taken
        strobe();
        chk("R6 disabled", 32'(take), 0);

        // R8: middle dropped, low taken
        mid = 0; ie_set = 1; idle();
        strobe();
        chk("R8 low level", 32'(vector), 32'h002C);
        lo = 0;

        // R7: short pulse on high latched while disabled, taken later
        hi = 1; idle(); hi = 0; idle();
        chk("R7 latched", 32'(pending[3]), 1);
        ie_set = 1; idle();
        strobe();
        chk("R7 vector", 32'(vector), 32'h003C);
        chk("R7 cleared", 32'(pending[3]), 0);

        // R5: NMI with enable off, and R3 over mid
        nmi = 1; mid = 1; idle();
        strobe();
        chk("R5 nmi", 32'(vector), 32'h0024);
        chk("R5 take", 32'(take), 1);
        // R5: pulse that has fallen is not taken
        nmi = 0; idle(); nmi = 1; idle(); nmi = 0; idle();
        strobe();
        chk("R5 fallen", 32'(take), 0);
        mid = 0;

        // R4: external acknowledge
        ie_set = 1; ext = 1; idle();
        strobe();
        chk("R4 ack", 32'(ext_ack), 1);
        chk("R4 vec", 32'(vector), 0);
        ext = 0;

        // R2: no strobe, no take
        ie_set = 1; lo = 1; idle(); idle();
        chk("R2 no strobe", 32'(take), 0);
        lo = 0;

        // R7: clear by mask write
        hi = 1; idle(); hi = 0; mask_wr = 1; mask_wdata = 4'b1000; idle(); idle();
        chk("R7 write clear", 32'(pending[3]), 0);

        // random phase compared against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            boundary   = ($urandom % 4) == 0;
            ie_set     = ($urandom % 3) == 0;
            ie_clr     = ($urandom % 8) == 0;
            mask_wr    = ($urandom % 10) == 0;
            mask_wdata = 4'($urandom);
            nmi        = ($urandom % 16) == 0 ? ~nmi : nmi;
            hi         = ($urandom % 5) == 0 ? ~hi : hi;
            mid        = ($urandom % 4) == 0 ? ~mid : mid;
            lo         = ($urandom % 4) == 0 ? ~lo : lo;
            ext        = ($urandom % 4) == 0 ? ~ext : ext;
        end
        idle(); idle();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule